// File: doc/BRIEF.md
# Digital AGC Gain Controller

This block owns the gain setting of a receive path and applies the digital share of that gain to a stream of I/Q samples. A 16-bit gain word carries a coarse attenuator flag in its top bit and a 15-bit attenuation code below it. The code is split between an analog gain stage (driven through `anaCode`) and an optional digital multiplier that lifts the samples by up to about 12 dB.

In manual mode, software writes the gain word and the block applies it no faster than a fixed minimum spacing. In automatic mode, a first-order loop takes over the attenuation code. On every valid sample it measures the larger of the two sample magnitudes, subtracts a reference level, scales the difference by a loop gain and adds the result to the code. The code saturates at its legal limits. Manual writes in automatic mode still set the coarse attenuator.

Top module: `agcGainUnit`

## Requirements
- R1: A synchronous reset, active high, clears `coarseAtten`, `gainCode`, `anaCode` and `outValid`, and cancels any held gain write.
- R2: An accepted gain write sets `coarseAtten` to bit 15 of the word from the next cycle on. In manual mode (`autoMode` = 0) it also sets `gainCode` to bits 14:0. `coarseAtten` changes only on an accepted write.
- R3: Accepted writes are at least 240 cycles apart. The first write after reset is accepted at once. A write that arrives too early is held and applied at the 240th clock edge after the previous acceptance. A newer early write replaces the held one.
- R4: With `digEn` = 0, `anaCode` = `gainCode[13:6]` whatever bit 14 holds, and samples pass through unchanged.
- R5: With `digEn` = 1 and `gainCode` of 0x4000 or above, `anaCode` = `gainCode[13:6]` and the digital gain is unity.
- R6: With `digEn` = 1 and `gainCode` at or below 0x3FFF, `anaCode` = 0. Each output sample is `floor((x*M + 2048) / 4096)`, where M = 4096 + floor(3*(0x3FFF - gainCode)/4). This gives unity at 0x3FFF and about 12 dB at 0x0000.
- R7: Scaled samples are clipped to the range -32768..32767.
- R8: `outValid` rises exactly one cycle after `sampleValid`. The output uses the gain state of the cycle in which the sample arrived.
- R9: In automatic mode, each valid sample moves `gainCode` by `floor((max(|I|,|Q|) - refLevel) * loopGain / 16)`, where |-32768| = 32768.
- R10: The loop saturates `gainCode` at 0 and at 0x7FFF, or at 0x3FFF while `digEn` = 0, and never wraps.
- R11: In automatic mode, writes leave `gainCode` alone, and the loop starts from the code that was in force when the mode was entered.
- R12: `gainCode` stays unchanged in a cycle with neither an accepted write nor a loop step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| autoMode | input | 1 | 1 = closed loop owns the attenuation code |
| digEn | input | 1 | Enables the digital gain stage |
| gainWrite | input | 1 | Strobe for a new gain word |
| gainWord | input | 16 | Bit 15 coarse attenuator, bits 14:0 attenuation code |
| refLevel | input | 16 | Loop reference magnitude |
| loopGain | input | 8 | Loop gain K |
| sampleValid | input | 1 | Input sample strobe |
| sampleI | input | 16 | Signed I sample |
| sampleQ | input | 16 | Signed Q sample |
| coarseAtten | output | 1 | Coarse attenuator enable |
| anaCode | output | 8 | Analog stage attenuation code |
| gainCode | output | 15 | Attenuation code in force |
| outValid | output | 1 | Output sample strobe |
| outI | output | 16 | Scaled signed I |
| outQ | output | 16 | Scaled signed Q |

## Verification
A corrupted rate-limit counter or held word shows at `gainCode` and `coarseAtten`. The symptom is a write landing a cycle early or late, or the wrong pending word being applied. It is visible the cycle after the 240th edge. A wrong integrator value shows on `gainCode` one cycle after the faulty sample. It then spreads into `anaCode` and into the scaling of every later sample. A mistake in the multiplier or the rounding appears on `outI`/`outQ` exactly one cycle after the input sample. The clip limits and the floor of negative loop steps are each driven into on purpose.

// File: rtl/agcPkg.sv
package agcPkg;
  // Strobes issued by the control to the datapath, one cycle wide.
  typedef struct packed {
    logic applyWord;    // accept the word on applyVal
    logic stepLoop;     // integrate the current sample
    logic loopOwnsCode; // automatic mode: writes touch only the coarse bit
  } agcStrobe_t;
endpackage

// File: rtl/agcControl.sv
module agcControl
  import agcPkg::*;
#(
  parameter int INTERVAL = 240,
  parameter int WORD_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              autoMode,
  input  logic              gainWrite,
  input  logic [WORD_W-1:0] gainWord,
  input  logic              sampleValid,
  output agcStrobe_t        strobe,
  output logic [WORD_W-1:0] applyVal
);
  localparam int CNT_W = $clog2(INTERVAL);

  logic [CNT_W-1:0]  holdCnt;
  logic              pendValid;
  logic [WORD_W-1:0] pendWord;
  logic              applyNow;

  // R3: accept when the spacing window has run out; the newest word wins
  always_comb begin
    applyNow            = (holdCnt == '0) && (gainWrite || pendValid);
    applyVal            = gainWrite ? gainWord : pendWord;
    strobe.applyWord    = applyNow;
    strobe.stepLoop     = autoMode && sampleValid;  // R9
    strobe.loopOwnsCode = autoMode;                 // R11
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt   <= '0;
      pendValid <= 1'b0;
      pendWord  <= '0;
    end else if (applyNow) begin
      holdCnt   <= CNT_W'(INTERVAL - 1);
      pendValid <= 1'b0;
    end else begin
      if (holdCnt != '0) holdCnt <= holdCnt - 1'b1;
      if (gainWrite) begin
        pendValid <= 1'b1;
        pendWord  <= gainWord;
      end
    end
  end
endmodule

// File: rtl/agcDatapath.sv
module agcDatapath
  import agcPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 15,
  parameter int ANA_W      = 8,
  parameter int K_W        = 8,
  parameter int LOOP_SHIFT = 4,
  parameter int MULT_FRAC  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  agcStrobe_t               strobe,
  input  logic [CODE_W:0]          applyVal,
  input  logic                     digEn,
  input  logic [K_W-1:0]           loopGain,
  input  logic [DATA_W-1:0]        refLevel,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleI,
  input  logic signed [DATA_W-1:0] sampleQ,
  output logic                     coarseAtten,
  output logic [CODE_W-1:0]        gainCode,
  output logic [ANA_W-1:0]         anaCode,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  localparam int LOW_W      = CODE_W - 1;
  localparam int MAG_W      = DATA_W + 1;
  localparam int ERR_W      = MAG_W + 1;
  localparam int STEP_W     = ERR_W + K_W + 1;
  localparam int ACC_W      = STEP_W + 1;
  localparam int MULT_W     = MULT_FRAC + 2;
  localparam int LIFT_W     = LOW_W + 2;
  localparam int SPAN_SHIFT = LOW_W - MULT_FRAC;
  localparam int PROD_W     = DATA_W + MULT_W + 1;
  localparam int SH_W       = PROD_W - MULT_FRAC;
  localparam logic [MULT_W-1:0] UNITY = MULT_W'(1 << MULT_FRAC);
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1 << (MULT_FRAC - 1));
  localparam logic signed [SH_W-1:0] SAT_HI = SH_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SH_W-1:0] SAT_LO = ~SAT_HI;

  function automatic logic [MAG_W-1:0] magOf(input logic signed [DATA_W-1:0] v);
    logic signed [MAG_W-1:0] w;
    w = MAG_W'(v);
    return w[MAG_W-1] ? MAG_W'(-w) : MAG_W'(w);
  endfunction

  logic              coarseReg;
  logic [CODE_W-1:0] codeReg;

  // ---- loop detector and integrator (R9, R10) ----
  logic [MAG_W-1:0]         magI, magQ, magMax;
  logic signed [ERR_W-1:0]  errVal;
  logic signed [STEP_W-1:0] stepRaw, stepVal;
  logic signed [ACC_W-1:0]  sumVal, maxCodeS;
  logic [CODE_W-1:0]        maxCode, nextCode;

  always_comb begin
    magI     = magOf(sampleI);
    magQ     = magOf(sampleQ);
    magMax   = (magI > magQ) ? magI : magQ;
    errVal   = $signed({1'b0, magMax}) - $signed({{(ERR_W - DATA_W){1'b0}}, refLevel});
    stepRaw  = STEP_W'(errVal) * STEP_W'($signed({1'b0, loopGain}));
    stepVal  = stepRaw >>> LOOP_SHIFT;
    sumVal   = ACC_W'($signed({1'b0, codeReg})) + ACC_W'(stepVal);
    maxCode  = digEn ? {CODE_W{1'b1}} : {1'b0, {LOW_W{1'b1}}};
    maxCodeS = ACC_W'($signed({1'b0, maxCode}));
    if (sumVal[ACC_W-1])       nextCode = '0;
    else if (sumVal > maxCodeS) nextCode = maxCode;
    else                        nextCode = sumVal[CODE_W-1:0];
  end

  // ---- gain state (R2, R11, R12) ----
  always_ff @(posedge clk) begin
    if (rst) begin
      coarseReg <= 1'b0;
      codeReg   <= '0;
    end else begin
      if (strobe.applyWord) coarseReg <= applyVal[CODE_W];
      if (strobe.stepLoop)
        codeReg <= nextCode;
      else if (strobe.applyWord && !strobe.loopOwnsCode)
        codeReg <= applyVal[CODE_W-1:0];
    end
  end

  // ---- code split between analog and digital stages (R4, R5, R6) ----
  logic              analogLive;
  logic [LOW_W-1:0]  digLift;
  logic [LIFT_W-1:0] liftProd;
  logic [LIFT_W-1:0] liftShift;
  logic [MULT_W-1:0] mult;

  always_comb begin
    analogLive = !digEn || codeReg[CODE_W-1];
    digLift    = ~codeReg[LOW_W-1:0];
    liftProd   = LIFT_W'(digLift) * LIFT_W'(3);
    liftShift  = liftProd >> SPAN_SHIFT;
    mult       = analogLive ? UNITY : UNITY + liftShift[MULT_W-1:0];
  end

  assign coarseAtten = coarseReg;
  assign gainCode    = codeReg;
  assign anaCode     = analogLive ? codeReg[LOW_W-1 -: ANA_W] : '0;

  // ---- per-lane scaling, rounding and clipping (R6, R7) ----
  logic signed [DATA_W-1:0] laneIn  [2];
  logic signed [DATA_W-1:0] laneOut [2];
  assign laneIn[0] = sampleI;
  assign laneIn[1] = sampleQ;

  for (genvar g = 0; g < 2; g++) begin : gLane
    logic signed [PROD_W-1:0] prod, rounded;
    logic signed [SH_W-1:0]   shifted;
    always_comb begin
      prod    = PROD_W'(laneIn[g]) * PROD_W'($signed({1'b0, mult}));
      rounded = prod + HALF_LSB;
      shifted = rounded[PROD_W-1:MULT_FRAC];
      if (shifted > SAT_HI)      laneOut[g] = SAT_HI[DATA_W-1:0];
      else if (shifted < SAT_LO) laneOut[g] = SAT_LO[DATA_W-1:0];
      else                       laneOut[g] = shifted[DATA_W-1:0];
    end
  end

  // R8: one register stage on the sample path
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= sampleValid;
      outI     <= laneOut[0];
      outQ     <= laneOut[1];
    end
  end
endmodule

// File: rtl/agcGainUnit.sv
module agcGainUnit
  import agcPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int CODE_W     = 15,
  parameter int ANA_W      = 8,
  parameter int K_W        = 8,
  parameter int LOOP_SHIFT = 4,
  parameter int MULT_FRAC  = 12,
  parameter int INTERVAL   = 240
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     autoMode,
  input  logic                     digEn,
  input  logic                     gainWrite,
  input  logic [CODE_W:0]          gainWord,
  input  logic [DATA_W-1:0]        refLevel,
  input  logic [K_W-1:0]           loopGain,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleI,
  input  logic signed [DATA_W-1:0] sampleQ,
  output logic                     coarseAtten,
  output logic [ANA_W-1:0]         anaCode,
  output logic [CODE_W-1:0]        gainCode,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ
);
  agcStrobe_t      ctlStrobe;
  logic [CODE_W:0] applyVal;

  agcControl #(.INTERVAL(INTERVAL), .WORD_W(CODE_W + 1)) i_ctl (
    .clk(clk), .rst(rst), .autoMode(autoMode), .gainWrite(gainWrite),
    .gainWord(gainWord), .sampleValid(sampleValid),
    .strobe(ctlStrobe), .applyVal(applyVal)
  );

  agcDatapath #(
    .DATA_W(DATA_W), .CODE_W(CODE_W), .ANA_W(ANA_W), .K_W(K_W),
    .LOOP_SHIFT(LOOP_SHIFT), .MULT_FRAC(MULT_FRAC)
  ) i_dp (
    .clk(clk), .rst(rst), .strobe(ctlStrobe), .applyVal(applyVal),
    .digEn(digEn), .loopGain(loopGain), .refLevel(refLevel),
    .sampleValid(sampleValid), .sampleI(sampleI), .sampleQ(sampleQ),
    .coarseAtten(coarseAtten), .gainCode(gainCode), .anaCode(anaCode),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );
endmodule

// File: rtl/agcGainUnitChk.sv
module agcGainUnitChk #(
  parameter int DATA_W   = 16,
  parameter int CODE_W   = 15,
  parameter int INTERVAL = 240
) (
  input logic              clk,
  input logic              rst,
  input logic              digEn,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleI,
  input logic              outValid,
  input logic [DATA_W-1:0] outI,
  input logic              coarseAtten,
  input logic [CODE_W-1:0] gainCode,
  input logic              applyWord,
  input logic              stepLoop
);
  localparam int GAP_W = $clog2(INTERVAL) + 1;
  localparam logic [CODE_W-1:0] HALF_MAX = CODE_W'((1 << (CODE_W - 1)) - 1);

  logic             pastOk;
  logic             seenApply;
  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    pastOk <= !rst;
    if (rst) begin
      seenApply <= 1'b0;
      gapCnt    <= '0;
    end else if (applyWord) begin
      seenApply <= 1'b1;
      gapCnt    <= '0;
    end else if (gapCnt != {GAP_W{1'b1}}) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst || !pastOk)
    outValid == $past(sampleValid)); // R8
  AST_BYPASS_WHEN_OFF: assert property (@(posedge clk) disable iff (rst || !pastOk)
    (outValid && !$past(digEn)) |-> outI == $past(sampleI)); // R4
  AST_COARSE_ONLY_ON_APPLY: assert property (@(posedge clk) disable iff (rst || !pastOk)
    !$past(applyWord) |-> $stable(coarseAtten)); // R2
  AST_MIN_SPACING: assert property (@(posedge clk) disable iff (rst || !pastOk)
    (applyWord && seenApply) |-> gapCnt >= GAP_W'(INTERVAL - 1)); // R3
  AST_CODE_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !pastOk)
    (!$past(applyWord) && !$past(stepLoop)) |-> $stable(gainCode)); // R12
  AST_NO_WRAP_HALF: assert property (@(posedge clk) disable iff (rst || !pastOk)
    ($past(stepLoop) && !$past(digEn)) |-> gainCode <= HALF_MAX); // R10
endmodule

bind agcGainUnit agcGainUnitChk i_chk (
  .clk(clk), .rst(rst), .digEn(digEn), .sampleValid(sampleValid),
  .sampleI(sampleI), .outValid(outValid), .outI(outI),
  .coarseAtten(coarseAtten), .gainCode(gainCode),
  .applyWord(ctlStrobe.applyWord), .stepLoop(ctlStrobe.stepLoop)
);

// File: tb/test_agcGainUnit.sv
module test_agcGainUnit;
  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic rst = 1'b1, autoMode = 1'b0, digEn = 1'b0, gainWrite = 1'b0, sampleValid = 1'b0;
  logic [15:0] gainWord = '0, refLevel = '0;
  logic [7:0] loopGain = '0;
  logic signed [15:0] sampleI = '0, sampleQ = '0;
  logic coarseAtten, outValid;
  logic [7:0] anaCode;
  logic [14:0] gainCode;
  logic signed [15:0] outI, outQ;

  agcGainUnit i_agcGainUnit (
    .clk(clk), .rst(rst), .autoMode(autoMode), .digEn(digEn), .gainWrite(gainWrite),
    .gainWord(gainWord), .refLevel(refLevel), .loopGain(loopGain),
    .sampleValid(sampleValid), .sampleI(sampleI), .sampleQ(sampleQ),
    .coarseAtten(coarseAtten), .anaCode(anaCode), .gainCode(gainCode),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int nChecks = 0, nFail = 0;
  typedef struct { int i; int q; } item_t;
  item_t sbq[$];

  // requirement model state
  int mCode = 0, mCoarse = 0, mHold = 0, mPend = 0, mPendWord = 0;
  bit mStarted = 0;

  task automatic checkVal(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int expAna(int code, bit de);   // R4 R5 R6
    return (!de || code >= 32'h4000) ? ((code & 32'h3FFF) >> 6) : 0;
  endfunction

  function automatic int expMult(int code, bit de);  // R6
    return (de && code < 32'h4000) ? 4096 + ((3 * (32'h3FFF - code)) >> 2) : 4096;
  endfunction

  function automatic int scaleExp(int x, int m);     // R6 R7
    longint p;
    p = longint'(x) * m + 2048;
    p = p >>> 12;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic int loopNext(int code, int xi, int xq, int rl, int k, bit de); // R9 R10
    int ai, aq, mag, st, n, hi;
    ai = (xi < 0) ? -xi : xi;
    aq = (xq < 0) ? -xq : xq;
    mag = (ai > aq) ? ai : aq;
    st = ((mag - rl) * k) >>> 4;
    n = code + st;
    hi = de ? 32'h7FFF : 32'h3FFF;
    if (n < 0) n = 0;
    if (n > hi) n = hi;
    return n;
  endfunction

  // model of one rising edge, evaluated with the inputs about to be sampled
  task automatic modelEdge();
    bit apply;
    int word, m;
    if (rst) begin
      mCode = 0; mCoarse = 0; mHold = 0; mPend = 0; mPendWord = 0;   // R1
    end else begin
      apply = (mHold == 0) && (gainWrite || mPend != 0);
      word  = gainWrite ? int'(gainWord) : mPendWord;
      if (sampleValid) begin                                          // R8
        m = expMult(mCode, digEn);
        sbq.push_back('{scaleExp(int'(sampleI), m), scaleExp(int'(sampleQ), m)});
      end
      if (sampleValid && autoMode)
        mCode = loopNext(mCode, int'(sampleI), int'(sampleQ), int'(refLevel), int'(loopGain), digEn);
      if (apply) begin                                                // R2 R3 R11
        mCoarse = (word >> 15) & 1;
        if (!autoMode) mCode = word & 32'h7FFF;
        mHold = 239; mPend = 0;
      end else begin
        if (mHold > 0) mHold--;
        if (gainWrite) begin mPend = 1; mPendWord = int'(gainWord); end
      end
    end
    mStarted = 1;
  endtask

  task automatic cyc();
    modelEdge();
    @(negedge clk);
    gainWrite = 1'b0;
    sampleValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) cyc();
  endtask

  task automatic writeGain(int w);
    gainWord = 16'(w); gainWrite = 1'b1; cyc();
  endtask

  task automatic sample(int xi, int xq);
    sampleI = 16'(xi); sampleQ = 16'(xq); sampleValid = 1'b1; cyc();
  endtask

  // scoreboard monitor, sampling 2 ns after each rising edge
  always begin
    @(posedge clk); #2;
    if (mStarted) begin
      checkVal("R2 coarse bit", int'(coarseAtten), mCoarse);
      checkVal("R3 R10 R11 R12 gain code", int'(gainCode), mCode);
      checkVal("R4 R5 R6 analog code", int'(anaCode), expAna(mCode, digEn));
      if (outValid) begin
        if (sbq.size() == 0) checkVal("R8 unexpected output strobe", 1, 0);
        else begin
          item_t e;
          e = sbq.pop_front();
          checkVal("R6 R7 sample I", int'(outI), e.i);
          checkVal("R6 R7 sample Q", int'(outQ), e.q);
        end
      end else if (sbq.size() != 0) begin
        checkVal("R8 missing output strobe", 0, 1);
        void'(sbq.pop_front());
      end
    end
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    @(negedge clk);
    idle(3);
    rst = 1'b0;
    // R1: reset values
    checkVal("R1 outValid after reset", int'(outValid), 0);
    checkVal("R1 gainCode after reset", int'(gainCode), 0);

    // R2 R4: first write is immediate; bypass with digital stage off
    writeGain(16'h9234);
    sample(1234, -5678);
    sample(32767, -32768);
    // R3: early writes are held, newest wins; bit 14 ignored by R4
    idle(20);
    writeGain(16'h0100);
    idle(5);
    writeGain(16'h4321);
    idle(100);
    checkVal("R3 held write not yet applied", int'(gainCode), 16'h1234);
    idle(140);

    // R5: upper half, analog only
    digEn = 1'b1;
    writeGain(16'h6000);
    sample(1000, -1000);
    idle(240);
    // R6 R7: full digital lift with clipping
    writeGain(16'h0000);
    sample(1000, -3);
    sample(30000, -20000);
    idle(240);
    writeGain(16'h2000);
    sample(12345, -7);
    sample(-1, 1);
    idle(4);

    // R9 R10 R11: closed loop from the current code
    refLevel = 16'd1000; loopGain = 8'd16; autoMode = 1'b1;
    sample(5000, -3000);
    sample(-32768, 0);
    sample(32767, 1);
    idle(5);                      // R12
    writeGain(16'h8000);          // R11: held, then coarse only
    for (int k = 0; k < 40; k++) sample(0, 0);
    idle(240);
    digEn = 1'b0;
    for (int k = 0; k < 3; k++) sample(32767, 32767);
    checkVal("R10 half-range ceiling", int'(gainCode), 16'h3FFF);
    refLevel = 16'd100; loopGain = 8'd3;
    sample(-50, 20);              // R9: negative step floors
    idle(3);
    autoMode = 1'b0;
    idle(3);
    checkVal("R8 scoreboard drained", sbq.size(), 0);
    finishRun();
  end
endmodule